// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the sixteen architectural integer registers of a processor core that switches among privileged operating modes. Some architectural registers are backed by more than one physical copy, and the current mode picks the copy that each access reaches. All modes share registers 0 to 7. The fast-interrupt mode has its own registers 8 to 12. Each of the five exception modes has its own stack pointer (register 13) and link register (register 14). System mode uses exactly the same storage as user mode.

The core reads two operands and writes one result per cycle, and every access is addressed by architectural register number. When an exception is taken, a separate entry port writes the return address into the link register of the mode being entered. The current mode does not affect that write. Register 15 is the program counter. It is not stored here: a read of index 15 returns the value on the program-counter input.

Top module: `banked_regfile`

## Requirements
- R1: After reset, every stored register reads as zero in every mode.
- R2: Registers 0 to 7 are one physical set. A write in any mode is seen by reads in every mode.
- R3: Registers 8 to 12 have one copy for mode code 2 (fast interrupt) and one copy shared by all other modes. A write to one copy does not change the other.
- R4: Registers 13 and 14 have a private copy for each exception mode: codes 2 (fast interrupt), 3 (normal interrupt), 4 (supervisor), 5 (abort) and 6 (undefined). A further copy is shared by user and system modes.
- R5: System mode (code 1) and user mode (code 0) read and write the same physical registers.
- R6: A read of index 15 returns `pc_value` on either port. A write to index 15 changes no register.
- R7: When `exc_take` is high and `exc_mode` is an exception mode, register 14 of `exc_mode` receives `exc_ret_addr` at the clock edge, whatever `cur_mode` is.
- R8: When `exc_take` is high with `exc_mode` set to user or system (code 0 or 1), no register changes.
- R9: When the entry write and the normal write reach the same physical register in the same cycle, the entry value is stored. When they reach different registers, both are stored.
- R10: A read of the physical register being written in the current cycle returns the new value. If both writes target that register, the entry value is returned.
- R11: Mode code 7 is not a defined mode and accesses the user bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_mode | input | 3 | Current processor mode code |
| rd_a_idx | input | 4 | Read port A architectural index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B architectural index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Normal write enable |
| wr_idx | input | 4 | Normal write architectural index |
| wr_data | input | 32 | Normal write data |
| exc_take | input | 1 | Exception entry strobe |
| exc_mode | input | 3 | Mode being entered |
| exc_ret_addr | input | 32 | Return address for the entered link register |
| pc_value | input | 32 | Value returned for index 15 |

## Verification
The same architectural index is written in one mode and read back in a second mode. This separates the shared registers from the fast-interrupt copies and the per-mode stack and link pairs, and it shows that system mode and code 7 alias the user bank. Same-cycle reads of a register being written check the bypass. An entry write to the same link register as a normal write shows that the entry value takes priority. Entry writes into non-current modes and into user or system mode show that the entry port follows `exc_mode` only. A reset in the middle of the run, with a changing program-counter value, separates stored registers from the index-15 path.

// File: rtl/banked_rf_pkg.sv
package banked_rf_pkg;
    localparam int DATA_W     = 32;
    localparam int MODE_W     = 3;
    localparam int IDX_W      = 4;
    localparam int SHARED_CNT = 8;
    localparam int FAST_LO    = 8;
    localparam int FAST_HI    = 14;
    localparam int SP_IDX     = 13;
    localparam int LR_IDX     = 14;
    localparam int PC_IDX     = 15;
    localparam int USER_CNT   = 15;
    localparam int FAST_CNT   = FAST_HI - FAST_LO + 1;
    localparam int PAIR_MODES = 4;
    localparam int FAST_BASE  = USER_CNT;
    localparam int PAIR_BASE  = FAST_BASE + FAST_CNT;
    localparam int NUM_PHYS   = PAIR_BASE + 2 * PAIR_MODES;
    localparam int PHYS_W     = $clog2(NUM_PHYS);

    typedef enum logic [MODE_W-1:0] {
        MD_USER   = 3'd0,
        MD_SYSTEM = 3'd1,
        MD_FAST   = 3'd2,
        MD_NORMAL = 3'd3,
        MD_SUPER  = 3'd4,
        MD_ABORT  = 3'd5,
        MD_UNDEF  = 3'd6
    } cpu_mode_e;

    function automatic logic is_exc_mode(input logic [MODE_W-1:0] m);
        return (m >= MD_FAST) && (m <= MD_UNDEF);
    endfunction
endpackage

// File: rtl/rf_bank_map.sv
module rf_bank_map
    import banked_rf_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    input  logic [IDX_W-1:0]  arch_i,
    output logic [PHYS_W-1:0] phys_o,
    output logic              stored_o
);
    always_comb begin
        phys_o   = PHYS_W'(arch_i);
        stored_o = (int'(arch_i) != PC_IDX);
        if (mode_i == MD_FAST && int'(arch_i) >= FAST_LO && int'(arch_i) <= FAST_HI) begin
            phys_o = PHYS_W'(FAST_BASE + int'(arch_i) - FAST_LO);
        end else if (int'(arch_i) == SP_IDX || int'(arch_i) == LR_IDX) begin
            case (mode_i)
                MD_NORMAL, MD_SUPER, MD_ABORT, MD_UNDEF:
                    phys_o = PHYS_W'(PAIR_BASE + 2 * (int'(mode_i) - int'(MD_NORMAL))
                                     + int'(arch_i) - SP_IDX);
                default: phys_o = PHYS_W'(arch_i);
            endcase
        end
    end
endmodule

// File: rtl/rf_store.sv
module rf_store
    import banked_rf_pkg::*;
#(
    parameter int RD_PORTS = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             n_we,
    input  logic [PHYS_W-1:0]                n_addr,
    input  logic [DATA_W-1:0]                n_data,
    input  logic                             e_we,
    input  logic [PHYS_W-1:0]                e_addr,
    input  logic [DATA_W-1:0]                e_data,
    input  logic [RD_PORTS-1:0][PHYS_W-1:0]  rd_addr,
    output logic [RD_PORTS-1:0][DATA_W-1:0]  rd_data
);
    logic [DATA_W-1:0] regs_q [NUM_PHYS];
    logic              collide;

    assign collide = n_we && e_we && (n_addr == e_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_PHYS; i++) regs_q[i] <= '0;
        end else begin
            if (n_we && !collide) regs_q[n_addr] <= n_data;
            if (e_we)             regs_q[e_addr] <= e_data;
        end
    end

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        assign rd_data[p] = (e_we && e_addr == rd_addr[p]) ? e_data :
                            (n_we && n_addr == rd_addr[p]) ? n_data :
                            regs_q[rd_addr[p]];
    end

    AST_ENTRY_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        e_we |=> regs_q[$past(e_addr)] == $past(e_data)); // R7
    AST_NORMAL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (n_we && !collide) |=> regs_q[$past(n_addr)] == $past(n_data)); // R9
    AST_ENTRY_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        collide |=> regs_q[$past(n_addr)] == $past(e_data)); // R9
    AST_BYPASS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        (n_we && !e_we && n_addr == rd_addr[0]) |-> rd_data[0] == n_data); // R10
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import banked_rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cur_mode,
    input  logic [3:0]        rd_a_idx,
    output logic [31:0]       rd_a_data,
    input  logic [3:0]        rd_b_idx,
    output logic [31:0]       rd_b_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [31:0]       wr_data,
    input  logic              exc_take,
    input  logic [2:0]        exc_mode,
    input  logic [31:0]       exc_ret_addr,
    input  logic [31:0]       pc_value
);
    localparam int MAPS   = 4;
    localparam int M_RDA  = 0;
    localparam int M_RDB  = 1;
    localparam int M_WR   = 2;
    localparam int M_EXC  = 3;

    logic [MAPS-1:0][MODE_W-1:0] map_mode;
    logic [MAPS-1:0][IDX_W-1:0]  map_arch;
    logic [MAPS-1:0][PHYS_W-1:0] map_phys;
    logic [MAPS-1:0]             map_stored;
    logic [1:0][PHYS_W-1:0]      rd_phys;
    logic [1:0][DATA_W-1:0]      rd_raw;
    logic                        n_we;
    logic                        e_we;

    assign map_mode = {exc_mode, cur_mode, cur_mode, cur_mode};
    assign map_arch = {IDX_W'(LR_IDX), wr_idx, rd_b_idx, rd_a_idx};

    for (genvar m = 0; m < MAPS; m++) begin : g_map
        rf_bank_map u_map (
            .mode_i   (map_mode[m]),
            .arch_i   (map_arch[m]),
            .phys_o   (map_phys[m]),
            .stored_o (map_stored[m])
        );
    end

    assign n_we    = wr_en && map_stored[M_WR];
    assign e_we    = exc_take && is_exc_mode(exc_mode);
    assign rd_phys = {map_phys[M_RDB], map_phys[M_RDA]};

    rf_store #(.RD_PORTS(2)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .n_we    (n_we),
        .n_addr  (map_phys[M_WR]),
        .n_data  (wr_data),
        .e_we    (e_we),
        .e_addr  (map_phys[M_EXC]),
        .e_data  (exc_ret_addr),
        .rd_addr (rd_phys),
        .rd_data (rd_raw)
    );

    assign rd_a_data = map_stored[M_RDA] ? rd_raw[0] : pc_value;
    assign rd_b_data = map_stored[M_RDB] ? rd_raw[1] : pc_value;

    AST_PC_PORT_A: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx == 4'd15) |-> rd_a_data == pc_value); // R6
    AST_PC_PORT_B: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_b_idx == 4'd15) |-> rd_b_data == pc_value); // R6
    AST_PC_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_idx == 4'd15) |-> !n_we); // R6
    AST_USER_ENTRY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_mode == MD_USER || exc_mode == MD_SYSTEM) |-> !e_we); // R8
    AST_LOW_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx < 4'd8) |-> map_phys[M_RDA] == PHYS_W'(rd_a_idx)); // R2
endmodule

// File: tb/test_banked_regfile.sv
module test_banked_regfile;
    typedef struct packed {
        logic [2:0]  mode;
        logic        we;
        logic [3:0]  widx;
        logic [31:0] wdata;
        logic        ee;
        logic [2:0]  emode;
        logic [31:0] edata;
        logic [3:0]  ra;
        logic [3:0]  rb;
        logic [31:0] xa;
        logic [31:0] xb;
    } vec_t;

    localparam logic [31:0] PC0 = 32'h0000_1000;
    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{3'd0,1'b1,4'd0, 32'hA0A0_0000,1'b0,3'd0,32'h0,4'd0, 4'd1, 32'hA0A0_0000,32'h0},          // R10 R1
        '{3'd2,1'b1,4'd8, 32'hF8F8_0008,1'b0,3'd0,32'h0,4'd0, 4'd8, 32'hA0A0_0000,32'hF8F8_0008},  // R2 R10
        '{3'd0,1'b1,4'd8, 32'h5858_0008,1'b0,3'd0,32'h0,4'd8, 4'd0, 32'h5858_0008,32'hA0A0_0000},  // R3
        '{3'd2,1'b0,4'd0, 32'h0,        1'b0,3'd0,32'h0,4'd8, 4'd9, 32'hF8F8_0008,32'h0},          // R3
        '{3'd1,1'b1,4'd13,32'h5555_000D,1'b0,3'd0,32'h0,4'd8, 4'd13,32'h5858_0008,32'h5555_000D},  // R5
        '{3'd0,1'b0,4'd0, 32'h0,        1'b0,3'd0,32'h0,4'd13,4'd15,32'h5555_000D,PC0},            // R5 R6
        '{3'd3,1'b1,4'd13,32'h1111_000D,1'b0,3'd0,32'h0,4'd13,4'd14,32'h1111_000D,32'h0},          // R4
        '{3'd4,1'b1,4'd14,32'hBAD0_000E,1'b1,3'd4,32'hE1E1_0001,4'd14,4'd13,32'hE1E1_0001,32'h0},  // R9 R10
        '{3'd4,1'b0,4'd0, 32'h0,        1'b0,3'd0,32'h0,4'd14,4'd13,32'hE1E1_0001,32'h0},          // R9
        '{3'd0,1'b1,4'd1, 32'hB1B1_0001,1'b1,3'd5,32'hE2E2_0002,4'd1, 4'd14,32'hB1B1_0001,32'h0},  // R7 R9
        '{3'd5,1'b0,4'd0, 32'h0,        1'b0,3'd0,32'h0,4'd14,4'd1, 32'hE2E2_0002,32'hB1B1_0001},  // R7 R2
        '{3'd7,1'b0,4'd0, 32'h0,        1'b0,3'd0,32'h0,4'd13,4'd8, 32'h5555_000D,32'h5858_0008},  // R11
        '{3'd0,1'b0,4'd0, 32'h0,        1'b1,3'd1,32'hE3E3_0003,4'd14,4'd14,32'h0,32'h0},          // R8
        '{3'd0,1'b1,4'd15,32'hDEAD_BEEF,1'b0,3'd0,32'h0,4'd14,4'd15,32'h0,PC0},                    // R8 R6
        '{3'd6,1'b0,4'd0, 32'h0,        1'b0,3'd0,32'h0,4'd13,4'd14,32'h0,32'h0},                  // R4
        '{3'd3,1'b0,4'd0, 32'h0,        1'b0,3'd0,32'h0,4'd13,4'd0, 32'h1111_000D,32'hA0A0_0000}   // R4 R2
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cur_mode = '0;
    logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0, exc_ret_addr = '0, pc_value = PC0;
    logic        wr_en = 1'b0, exc_take = 1'b0;
    logic [2:0]  exc_mode = '0;
    int          checks = 0, fails = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    banked_regfile i_banked_regfile (
        .clk(clk), .rst_n(rst_n), .cur_mode(cur_mode),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .exc_take(exc_take), .exc_mode(exc_mode), .exc_ret_addr(exc_ret_addr),
        .pc_value(pc_value)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] m, input logic we, input logic [3:0] wi,
                         input logic [31:0] wd, input logic ee, input logic [2:0] em,
                         input logic [31:0] ed, input logic [3:0] ra, input logic [3:0] rb);
        @(negedge clk);
        cur_mode = m; wr_en = we; wr_idx = wi; wr_data = wd;
        exc_take = ee; exc_mode = em; exc_ret_addr = ed;
        rd_a_idx = ra; rd_b_idx = rb;
        #1;
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: reset state seen across modes
        drive(3'd2, 0, 0, 0, 0, 0, 0, 4'd12, 4'd14);
        check("R1 fiq r12", rd_a_data, 32'h0);
        check("R1 fiq r14", rd_b_data, 32'h0);

        for (int v = 0; v < NV; v++) begin
            drive(VEC[v].mode, VEC[v].we, VEC[v].widx, VEC[v].wdata, VEC[v].ee,
                  VEC[v].emode, VEC[v].edata, VEC[v].ra, VEC[v].rb);
            check($sformatf("vector %0d port A (R2-R11)", v), rd_a_data, VEC[v].xa);
            check($sformatf("vector %0d port B (R2-R11)", v), rd_b_data, VEC[v].xb);
        end

        // R7: fast-interrupt entry from user mode hits fiq r14 only
        drive(3'd0, 0, 0, 0, 1, 3'd2, 32'hF1F1_000E, 4'd14, 4'd0);
        check("R7 user r14 untouched", rd_a_data, 32'h0);
        drive(3'd2, 0, 0, 0, 0, 0, 0, 4'd14, 4'd13);
        check("R7 fiq r14 loaded", rd_a_data, 32'hF1F1_000E);
        check("R4 fiq r13 private", rd_b_data, 32'h0);

        // R10: port B bypass of entry write
        drive(3'd6, 0, 0, 0, 1, 3'd6, 32'hC0DE_0006, 4'd13, 4'd14);
        check("R10 entry bypass", rd_b_data, 32'hC0DE_0006);

        // R6: pc follows input
        pc_value = 32'h0000_2468;
        drive(3'd4, 0, 0, 0, 0, 0, 0, 4'd15, 4'd15);
        check("R6 pc port A", rd_a_data, 32'h0000_2468);
        check("R6 pc port B", rd_b_data, 32'h0000_2468);

        // R1: second reset clears stored state
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        drive(3'd5, 0, 0, 0, 0, 0, 0, 4'd14, 4'd0);
        check("R1 abort r14 cleared", rd_a_data, 32'h0);
        check("R1 r0 cleared", rd_b_data, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule